// File: doc/BRIEF.md
# Three-Axis Sample Ready and Overwrite Status Tracker

This block holds the status byte of a three-axis field sensor. It tells software when new samples are waiting and when a sample was replaced before anyone read it. The measurement core sends one pulse per axis each time that axis finishes an acquisition. The bus interface sends one strobe per axis each time the high byte of that axis's result is read. From these two sets of events the block keeps two kinds of flag:

- Per-axis flags, which are set by their own axis and cleared by their own high-byte read.
- Aggregate flags, which cover a whole set of samples across the enabled axes.

The aggregate ready flag also drives an active-high interrupt line. Software can therefore wait for the interrupt, read the high bytes, and know that the line drops once the set has been fully retrieved.

A per-axis pending mask records which enabled axes still have an unread high byte. The aggregate flags clear only when this mask empties. A fresh sample on an axis marks that axis pending again. Any clear event that falls in the same cycle as a set event loses, so a new sample is never dropped.

Top module: `axis_ready_tracker`

## Requirements
- R1: After reset the status byte is 0x00 and the interrupt is low. The status byte layout is bit 7 aggregate overwrite, bits 6/5/4 Z/Y/X overwrite, bit 3 aggregate ready, bits 2/1/0 Z/Y/X ready. Axis index 0 is X, 1 is Y and 2 is Z.
- R2: A completion pulse on an axis sets that axis's ready bit on the next cycle. This happens whether or not the axis is enabled.
- R3: A high-byte read strobe on an axis clears both that axis's ready bit and its overwrite bit on the next cycle. This applies when no completion pulse arrives on that axis in the same cycle.
- R4: A completion pulse on an axis whose ready bit is already set also sets that axis's overwrite bit.
- R5: A completion pulse on an enabled axis sets the aggregate ready bit. A completion pulse on a disabled axis leaves the aggregate bits unchanged.
- R6: The aggregate ready bit stays set until the high bytes of all pending enabled axes have been read. Reading only some of them keeps it set.
- R7: The aggregate overwrite bit sets when an enabled axis completes again while that axis is still pending. It clears in the same cycle that the aggregate ready bit clears.
- R8: The interrupt output always equals the aggregate ready bit.
- R9: When a completion pulse and a read strobe hit the same axis in the same cycle, the set wins. The ready bit ends set, and the axis is pending again.
- R10: Pending tracking restarts per axis. A new sample on an axis already read in the current set makes it pending again. Disabling an axis drops it from the pending mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| axis_en | input | 3 | Axes that take part in the aggregate flags (bit 0 X, bit 1 Y, bit 2 Z) |
| sample_done | input | 3 | One-cycle acquisition-complete pulse per axis |
| msb_read | input | 3 | One-cycle high-byte read strobe per axis |
| status | output | 8 | Status byte, layout as in R1 |
| irq | output | 1 | Active-high interrupt, mirrors aggregate ready |

## Verification
The bench goes after the following corner cases:

- **Partial retrieval of a set (R6).** A design that clears the aggregate bit on the first read would drop the interrupt while Y and Z data remain unread.
- **Same-cycle completion and read (R9).** A clear-wins design loses the sample: the ready bit stays low and the interrupt never fires.
- **Second completion on an unread axis (R4, R7).** This must raise both overwrite bits. A design that keys the aggregate overwrite on a different axis, or never clears it, reports phantom overruns.
- **Changes to the enable mask (R5, R10).** A disabled axis must not hold the interrupt high and must not raise it.

// File: rtl/axtrk_pkg.sv
package axtrk_pkg;

    localparam int AXES     = 3;
    localparam int STAT_W   = 2 * AXES + 2;

    typedef struct packed {
        logic            all_ovr;
        logic [AXES-1:0] ovr;
        logic            all_rdy;
        logic [AXES-1:0] rdy;
    } stat_t;

    function automatic logic any_set(input logic [AXES-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/axis_flag_cell.sv
module axis_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic rd,
    output logic rdy,
    output logic ovr
);
    // set has priority over clear on both flags
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0;
            ovr <= 1'b0;
        end else begin
            rdy <= done | (rdy & ~rd);
            ovr <= (done & rdy) | (ovr & ~rd);
        end
    end
endmodule

// File: rtl/set_tracker.sv
module set_tracker
    import axtrk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AXES-1:0] en,
    input  logic [AXES-1:0] done,
    input  logic [AXES-1:0] rd,
    output logic            all_rdy,
    output logic            all_ovr
);
    logic [AXES-1:0] pend;
    logic [AXES-1:0] pend_n;
    logic            hit_pending;

    always_comb begin
        pend_n      = ((pend & ~rd) | done) & en;
        hit_pending = any_set(done & en & pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            all_rdy <= 1'b0;
            all_ovr <= 1'b0;
        end else begin
            pend    <= pend_n;
            all_rdy <= any_set(pend_n);
            all_ovr <= any_set(pend_n) & (all_ovr | hit_pending);
        end
    end
endmodule

// File: rtl/axis_ready_tracker.sv
module axis_ready_tracker
    import axtrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AXES-1:0]   axis_en,
    input  logic [AXES-1:0]   sample_done,
    input  logic [AXES-1:0]   msb_read,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    stat_t           st;
    logic [AXES-1:0] rdy_v;
    logic [AXES-1:0] ovr_v;
    logic            agg_rdy;
    logic            agg_ovr;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        axis_flag_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .done (sample_done[a]),
            .rd   (msb_read[a]),
            .rdy  (rdy_v[a]),
            .ovr  (ovr_v[a])
        );
    end

    set_tracker u_set (
        .clk     (clk),
        .rst     (rst),
        .en      (axis_en),
        .done    (sample_done),
        .rd      (msb_read),
        .all_rdy (agg_rdy),
        .all_ovr (agg_ovr)
    );

    always_comb begin
        st.all_ovr = agg_ovr;
        st.ovr     = ovr_v;
        st.all_rdy = agg_rdy;
        st.rdy     = rdy_v;
    end

    assign status = st;
    assign irq    = agg_rdy;
endmodule

// File: rtl/axis_ready_tracker_chk.sv
module axis_ready_tracker_chk
    import axtrk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [AXES-1:0]   axis_en,
    input logic [AXES-1:0]   sample_done,
    input logic [AXES-1:0]   msb_read,
    input logic [STAT_W-1:0] status,
    input logic              irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq));

    assert_ready_set_R2: assert property (@(posedge clk) disable iff (rst)
        sample_done[0] |=> status[0]);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (msb_read[1] && !sample_done[1]) |=> (!status[1] && !status[5]));

    assert_overwrite_set_R4: assert property (@(posedge clk) disable iff (rst)
        (sample_done[2] && status[2]) |=> status[6]);

    assert_agg_set_R5: assert property (@(posedge clk) disable iff (rst)
        (|(sample_done & axis_en)) |=> status[3]);

    assert_agg_ovr_implies_rdy_R7: assert property (@(posedge clk) disable iff (rst)
        status[7] |-> status[3]);

    assert_irq_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        irq == status[3]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (sample_done[0] && msb_read[0] && axis_en[0]) |=> (status[0] && irq));
endmodule

bind axis_ready_tracker axis_ready_tracker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .axis_en     (axis_en),
    .sample_done (sample_done),
    .msb_read    (msb_read),
    .status      (status),
    .irq         (irq)
);

// File: tb/test_axis_ready_tracker.sv
module test_axis_ready_tracker;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] axis_en;
    logic [2:0] sample_done;
    logic [2:0] msb_read;
    logic [7:0] status;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    // reference state, kept per requirement
    logic [2:0] m_rdy, m_ovr, m_pend;
    logic       m_all_rdy, m_all_ovr;

    always #10 clk = ~clk;

    axis_ready_tracker i_axis_ready_tracker (
        .clk(clk), .rst(rst), .axis_en(axis_en), .sample_done(sample_done),
        .msb_read(msb_read), .status(status), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input logic act_irq, input string tag);
        total++;
        if (act !== exp || act_irq !== exp[3]) begin
            bad++;
            $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b",
                     tag, act, act_irq, exp, exp[3]);
        end
    endtask

    task automatic drive(input logic [2:0] d, input logic [2:0] r,
                         input logic [2:0] e, input string tag);
        item_t it;
        logic  ow_hit;
        @(negedge clk);
        sample_done = d;
        msb_read    = r;
        axis_en     = e;
        ow_hit      = 1'b0;
        for (int a = 0; a < 3; a++) begin
            if (d[a]) begin
                // R4: overwrite when ready still set; R2: ready sets
                if (m_rdy[a]) m_ovr[a] = 1'b1;
                m_rdy[a] = 1'b1;
            end else if (r[a]) begin
                m_rdy[a] = 1'b0;   // R3
                m_ovr[a] = 1'b0;
            end
            if (!e[a]) begin
                m_pend[a] = 1'b0;  // R10 disabled axis dropped
            end else if (d[a]) begin
                if (m_pend[a]) ow_hit = 1'b1;  // R7
                m_pend[a] = 1'b1;              // R9 / R10
            end else if (r[a]) begin
                m_pend[a] = 1'b0;
            end
        end
        m_all_rdy = (m_pend != 3'b000);               // R5 / R6
        m_all_ovr = m_all_rdy && (m_all_ovr || ow_hit);
        it.exp = {m_all_ovr, m_ovr[2], m_ovr[1], m_ovr[0],
                  m_all_rdy, m_rdy[2], m_rdy[1], m_rdy[0]};
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare one cycle after each driven stimulus
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(status, it.exp, irq, it.tag);
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: status=%02h expected run to finish", status);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; axis_en = 3'b111; sample_done = '0; msb_read = '0;
        m_rdy = '0; m_ovr = '0; m_pend = '0; m_all_rdy = 0; m_all_ovr = 0;
        repeat (3) @(negedge clk);
        check(status, 8'h00, irq, "R1 reset state");
        rst = 1'b0;

        drive(3'b001, 3'b000, 3'b111, "R2 R5 R8 x sample");
        drive(3'b110, 3'b000, 3'b111, "R2 y z samples");
        drive(3'b000, 3'b001, 3'b111, "R6 read x only");
        drive(3'b000, 3'b010, 3'b111, "R6 read y only");
        drive(3'b000, 3'b100, 3'b111, "R6 read z completes set");
        drive(3'b001, 3'b000, 3'b111, "R2 x sample again");
        drive(3'b001, 3'b000, 3'b111, "R4 R7 x overwritten");
        drive(3'b000, 3'b001, 3'b111, "R3 R7 read x clears overwrite");
        drive(3'b010, 3'b000, 3'b001, "R5 disabled y sample");
        drive(3'b000, 3'b010, 3'b001, "R3 read y");
        drive(3'b001, 3'b001, 3'b001, "R9 sample and read same cycle");
        drive(3'b001, 3'b001, 3'b001, "R9 R4 overlap keeps overwrite");
        drive(3'b000, 3'b001, 3'b001, "R3 read x");
        drive(3'b001, 3'b000, 3'b111, "R2 x sample");
        drive(3'b010, 3'b001, 3'b111, "R10 y new while x read");
        drive(3'b001, 3'b000, 3'b111, "R10 x re-pending");
        drive(3'b000, 3'b011, 3'b111, "R6 read x y");
        drive(3'b011, 3'b000, 3'b111, "R2 x y samples");
        drive(3'b000, 3'b001, 3'b001, "R10 disable y then read x");
        drive(3'b000, 3'b010, 3'b001, "R3 read y");
        drive(3'b100, 3'b000, 3'b111, "R5 z sample");
        drive(3'b000, 3'b000, 3'b111, "R8 idle hold");
        drive(3'b000, 3'b100, 3'b111, "R6 read z");
        @(negedge clk);
        sample_done = '0; msb_read = '0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule